// File: doc/BRIEF.md
# Multi-Channel Direct Memory Access Engine

This block moves data without processor help. It has several independent channels and one shared bus master port. Each channel holds two addresses, one for the peripheral side and one for the memory side, plus a remaining-item count and a control word. A channel moves items of a chosen width from its read side to its write side. In peripheral mode, each item waits for a request line. In memory-to-memory mode, items run back to back as soon as the channel is enabled.

Every item is one read followed by one write on the shared bus. After each item, a priority arbiter chooses the next channel, so a more urgent channel can cut in between two items of a long transfer. Each channel keeps three sticky event flags: half-way, complete and bus-error. Each flag has its own interrupt enable. Software reads all the flags from a single status word and clears them through a write-one-to-clear word.

Top module: `dma_engine`

Configuration addresses: channel `c` register `r` sits at `c*4 + r`, with r=0 control, r=1 count, r=2 peripheral-side address, r=3 memory-side address. Address 0x10 reads status and address 0x11 is the clear word, for the default of four channels.

## Requirements
- R1: Among pending channels, the one with the highest 2-bit priority (control bits [11:10], 3 = most urgent) is granted the next item.
- R2: When pending channels share the top priority level, the lowest channel index is granted.
- R3: The 16-bit count (register 1) drops by one per completed item, and a channel with a count of zero moves no item.
- R4: Control bits [7:6] give the peripheral-side size and bits [9:8] give the memory-side size (0 byte, 1 half-word, 2 word). The read value is cut to the read-side size and then to the write-side size. Bit 4 (peripheral side) and bit 5 (memory side) enable an address step of 1, 2 or 4 bytes per item for that side.
- R5: Control bit 1 set makes the memory-side address the read side. When it is clear, the peripheral-side address is read.
- R6: In peripheral mode (bit 3 clear), an item starts only while the channel's request line is high. Each item is acknowledged by a single-cycle pulse on the channel's ack line in the cycle after its write completes. The request must be low by the next clock edge.
- R7: With bit 3 (memory-to-memory) set and bit 0 (enable) set, items run without any request until the count is zero.
- R8: With bit 2 (circular) set in peripheral mode, reaching zero reloads the programmed count and both start addresses. In memory-to-memory mode, bit 2 has no effect.
- R9: The half-way flag (status bit 3c) sets when the remaining count reaches the programmed count divided by two, rounded down.
- R10: The complete flag (status bit 3c+1) sets when the count reaches zero. irq[c] is high while any flag of channel c is set whose enable bit is set (bits 12 half-way, 13 complete, 14 error).
- R11: Flags read from the status word at 0x10. Writing 1 to a bit of the clear word at 0x11 clears that flag and leaves the other flags unchanged. After reset, all registers and flags are zero.
- R12: A bus error on a read or a write sets the error flag (status bit 3c+2) and clears the channel's enable bit. The count is left unchanged, and other channels keep running.
- R13: The bus address and direction hold steady until the item's response arrives, and a higher-priority channel is granted at the next item boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| mem_req | output | 1 | Bus access request, held until response |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size: 0 byte, 1 half-word, 2 word |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| dreq | input | NCH | Per-channel peripheral request |
| dack | output | NCH | Per-channel single-cycle item acknowledge |
| irq | output | NCH | Per-channel interrupt |

## Verification
The data path is tried with every pairing of read-side and write-side size. Each pairing runs with both addresses stepping, and two more runs hold one side's address still. Together these separate truncation order, step size and direction of each side. Request-driven channels are stepped one item at a time, so the half-way point, the circular reload of the count and address, and the width of the acknowledge pulse are each observed exactly. Arbitration is tried three ways: two requests raised on the same edge at different levels, the same two at equal levels, and a high-level request arriving during a long memory-to-memory run. These tell priority order, tie order and item-boundary preemption apart. A failing address on one channel running alongside a healthy one shows that an error stays confined to its own channel.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // Per-channel control word, bit 0 (en) up to bit 14 (ie[2]).
  typedef struct packed {
    logic [2:0] ie;    // {err, done, half}
    logic [1:0] prio;
    logic [1:0] msz;
    logic [1:0] psz;
    logic       minc;
    logic       pinc;
    logic       m2m;
    logic       circ;
    logic       dir;   // 1: memory side is read
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_PADR = 2'd2;
  localparam logic [1:0] REG_MADR = 2'd3;

  // Keep only the bytes that an item of size sz carries.
  function automatic logic [31:0] size_fit(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

  // Address advance per item for one side.
  function automatic logic [31:0] addr_step(input logic inc, input logic [1:0] sz);
    if (!inc) return 32'd0;
    case (sz)
      2'd0:    return 32'd1;
      2'd1:    return 32'd2;
      default: return 32'd4;
    endcase
  endfunction

  // Remaining count at which the half-way flag fires.
  function automatic logic [15:0] half_mark(input logic [15:0] n);
    return n >> 1;
  endfunction
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pend,
  input  logic [2*NCH-1:0]  prio,
  output logic              gnt_v,
  output logic [CH_W-1:0]   gnt_idx
);
  logic [1:0] best;

  // Strict greater-than keeps the lower index on a tie.
  always_comb begin
    gnt_v   = 1'b0;
    gnt_idx = '0;
    best    = 2'd0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && (!gnt_v || prio[2*i +: 2] > best)) begin
        gnt_v   = 1'b1;
        gnt_idx = CH_W'(i);
        best    = prio[2*i +: 2];
      end
    end
  end

  logic [1:0] win_p;
  assign win_p = prio[2*gnt_idx +: 2];

  // R1
  grant_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |-> (gnt_v && pend[gnt_idx]));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic [1:0] pg;
    assign pg = prio[2*g +: 2];
    // R1
    prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_v && pend[g]) |-> (pg <= win_p));
    // R2
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_v && pend[g] && pg == win_p) |-> (CH_W'(g) >= gnt_idx));
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan import dma_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_cnt,
  input  logic        wr_padr,
  input  logic        wr_madr,
  input  logic [31:0] wdata,
  input  logic [2:0]  clr,
  input  logic        item_done,
  input  logic        item_err,
  input  logic        req_in,
  input  logic        ack_busy,
  output ctrl_t       ctrl,
  output logic [15:0] cnt,
  output logic [31:0] padr,
  output logic [31:0] madr,
  output logic        pend,
  output logic [2:0]  flags,
  output logic        irq
);
  logic [15:0] shadow;
  logic [31:0] pbase, mbase;
  logic [15:0] cnt_nx;
  logic        wrap;

  assign cnt_nx = cnt - 16'd1;
  assign wrap   = (cnt_nx == 16'd0) && ctrl.circ && !ctrl.m2m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      cnt    <= '0;
      shadow <= '0;
      padr   <= '0;
      madr   <= '0;
      pbase  <= '0;
      mbase  <= '0;
      flags  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_cnt) begin
        cnt    <= wdata[15:0];
        shadow <= wdata[15:0];
      end
      if (wr_padr) begin
        padr  <= wdata;
        pbase <= wdata;
      end
      if (wr_madr) begin
        madr  <= wdata;
        mbase <= wdata;
      end
      flags <= flags & ~clr;
      if (item_done) begin
        if (cnt_nx == half_mark(shadow)) flags[0] <= 1'b1;
        if (cnt_nx == 16'd0)             flags[1] <= 1'b1;
        if (wrap) begin
          cnt  <= shadow;
          padr <= pbase;
          madr <= mbase;
        end else begin
          cnt  <= cnt_nx;
          padr <= padr + addr_step(ctrl.pinc, ctrl.psz);
          madr <= madr + addr_step(ctrl.minc, ctrl.msz);
        end
      end
      if (item_err) begin
        flags[2] <= 1'b1;
        ctrl.en  <= 1'b0;
      end
    end
  end

  assign pend = ctrl.en && (cnt != 16'd0) && (ctrl.m2m || (req_in && !ack_busy));
  assign irq  = |(flags & ctrl.ie);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !wr_cnt && cnt > 16'd1) |=> (cnt == $past(cnt) - 16'd1));
  // R8
  m2m_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !wr_cnt && ctrl.m2m && cnt == 16'd1) |=> (cnt == 16'd0));
  // R9
  half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && !wr_cnt && {1'b0, cnt} == {1'b0, shadow >> 1} + 17'd1) |=> flags[0]);
  // R12
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    item_err |=> (!ctrl.en && flags[2]));
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int NCH  = 4,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int AW   = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [NCH-1:0]    dreq,
  output logic [NCH-1:0]    dack,
  output logic [NCH-1:0]    irq
);
  ctrl_t       ctrls [NCH];
  logic [15:0] cnts  [NCH];
  logic [31:0] padrs [NCH];
  logic [31:0] madrs [NCH];
  logic [2:0]  flg   [NCH];

  logic [NCH-1:0]   pend, item_done, item_err, dack_nx, dack_q;
  logic [2*NCH-1:0] prio_flat;
  logic [3*NCH-1:0] stat_flat;
  logic             gnt_v;
  logic [CH_W-1:0]  gnt_idx, cur;
  eng_st_t          st;
  logic [31:0]      buf_q;

  logic            glob;
  logic [CH_W-1:0] chsel;
  logic [1:0]      rsel;
  logic            clr_hit;
  assign glob    = cfg_addr[AW-1];
  assign chsel   = cfg_addr[CH_W+1:2];
  assign rsel    = cfg_addr[1:0];
  assign clr_hit = cfg_we && glob && (cfg_addr[1:0] == 2'd1);

  // Internal events, named for the assertions.
  logic busy, rd_ok, wr_ok;
  assign busy  = (st != ST_IDLE);
  assign rd_ok = (st == ST_RD) && mem_ack && !mem_err;
  assign wr_ok = (st == ST_WR) && mem_ack && !mem_err;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic me;
    assign hit = cfg_we && !glob && (chsel == CH_W'(i));
    assign me  = (cur == CH_W'(i));
    assign item_done[i] = wr_ok && me;
    assign item_err[i]  = busy && mem_err && me;
    assign dack_nx[i]   = item_done[i] && !ctrls[i].m2m;

    dma_chan u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (hit && rsel == REG_CTRL),
      .wr_cnt    (hit && rsel == REG_CNT),
      .wr_padr   (hit && rsel == REG_PADR),
      .wr_madr   (hit && rsel == REG_MADR),
      .wdata     (cfg_wdata),
      .clr       (clr_hit ? cfg_wdata[3*i +: 3] : 3'b000),
      .item_done (item_done[i]),
      .item_err  (item_err[i]),
      .req_in    (dreq[i]),
      .ack_busy  (dack_q[i]),
      .ctrl      (ctrls[i]),
      .cnt       (cnts[i]),
      .padr      (padrs[i]),
      .madr      (madrs[i]),
      .pend      (pend[i]),
      .flags     (flg[i]),
      .irq       (irq[i])
    );

    assign prio_flat[2*i +: 2] = ctrls[i].prio;
    assign stat_flat[3*i +: 3] = flg[i];

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dack[i] |=> !dack[i]);
    // R6
    ack_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dack[i]) |-> $past(item_done[i]));
  end

  dma_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .prio    (prio_flat),
    .gnt_v   (gnt_v),
    .gnt_idx (gnt_idx)
  );

  // One item per grant: read, then write, then back to arbitration.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cur    <= '0;
      buf_q  <= '0;
      dack_q <= '0;
    end else begin
      dack_q <= dack_nx;
      case (st)
        ST_IDLE: if (gnt_v) begin
          cur <= gnt_idx;
          st  <= ST_RD;
        end
        ST_RD: begin
          if (mem_err) st <= ST_IDLE;
          else if (mem_ack) begin
            buf_q <= size_fit(mem_rdata, ctrls[cur].dir ? ctrls[cur].msz : ctrls[cur].psz);
            st    <= ST_WR;
          end
        end
        default: if (mem_ack || mem_err) st <= ST_IDLE;
      endcase
    end
  end

  ctrl_t act;
  logic  rd_mem_side;
  assign act         = ctrls[cur];
  assign rd_mem_side = (st == ST_WR) ? !act.dir : act.dir;

  assign dack      = dack_q;
  assign mem_req   = busy;
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = rd_mem_side ? madrs[cur] : padrs[cur];
  assign mem_size  = rd_mem_side ? act.msz : act.psz;
  assign mem_wdata = size_fit(buf_q, act.dir ? act.psz : act.msz);

  always_comb begin
    cfg_rdata = 32'd0;
    if (glob) begin
      if (cfg_addr[1:0] == 2'd0) cfg_rdata = 32'(stat_flat);
    end else if (int'(chsel) < NCH) begin
      case (rsel)
        REG_CTRL: cfg_rdata = {{(32-CTRL_W){1'b0}}, ctrls[chsel]};
        REG_CNT:  cfg_rdata = {16'd0, cnts[chsel]};
        REG_PADR: cfg_rdata = padrs[chsel];
        default:  cfg_rdata = madrs[chsel];
      endcase
    end
  end

  // R13
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R5
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> (mem_req && mem_we));
endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  localparam int NCH = 4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [NCH-1:0] dreq = '0;
  logic [NCH-1:0] dack, irq;

  dma_engine #(.NCH(NCH)) dut (.*);

  int nchk = 0, nerr = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] expm [0:1023];

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + 5);
  endfunction

  // Bus slave: zero-wait, addresses with bit 31 set fail.
  always_comb begin
    mem_ack   = mem_req && !mem_addr[31];
    mem_err   = mem_req && mem_addr[31];
    mem_rdata = {mem[(mem_addr[9:0] + 10'd3)], mem[(mem_addr[9:0] + 10'd2)],
                 mem[(mem_addr[9:0] + 10'd1)], mem[mem_addr[9:0]]};
  end
  always @(posedge clk) begin
    if (mem_req && mem_we && mem_ack) begin
      for (int k = 0; k < (1 << mem_size); k++)
        mem[mem_addr[9:0] + 10'(k)] <= mem_wdata[8*k +: 8];
    end
  end

  logic        armed = 1'b0;
  logic [31:0] first_rd = '0;
  always @(negedge clk) begin
    if (armed && mem_req && !mem_we) begin
      first_rd = mem_addr;
      armed    = 1'b0;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ra(input int c, input int r);
    return 5'(c * 4 + r);
  endfunction
  localparam logic [4:0] A_STAT = 5'h10, A_CLR = 5'h11;

  function automatic logic [31:0] mk(input bit en, dir, circ, m2m, pinc, minc,
                                     input logic [1:0] psz, msz, prio, input logic [2:0] ie);
    return {17'd0, ie, prio, msz, psz, minc, pinc, m2m, circ, dir, en};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_bit(input int b, input string tag);
    logic [31:0] s;
    bit got = 0;
    for (int n = 0; n < 3000 && !got; n++) begin
      @(negedge clk);
      rd(A_STAT, s);
      got = s[b];
    end
    if (!got) chk(tag, 32'd0, 32'd1);
  endtask

  task automatic setup(input int c, input logic [31:0] pa, ma, input int n);
    wr(ra(c, 0), 32'd0);
    wr(ra(c, 2), pa);
    wr(ra(c, 3), ma);
    wr(ra(c, 1), 32'(n));
  endtask

  task automatic serve(input int c);
    bit got = 0;
    @(negedge clk);
    dreq[c] = 1'b1;
    for (int n = 0; n < 500 && !got; n++) begin
      @(negedge clk);
      if (dack[c]) begin
        dreq[c] = 1'b0;
        got = 1;
      end
    end
    if (!got) chk("R6 ack seen", 32'd0, 32'd1);
    @(negedge clk);
    chk("R6 ack one cycle", 32'(dack[c]), 32'd0);
  endtask

  task automatic load_word(input int a, output logic [31:0] w);
    w = {mem[(a + 3) & 1023], mem[(a + 2) & 1023], mem[(a + 1) & 1023], mem[a & 1023]};
  endtask

  // Memory-to-memory copy on channel 0, checked byte-exact.
  task automatic run_copy(input logic [1:0] psz, msz, input bit pinc, minc, circ);
    int src = 'h40, dst = 'h200;
    logic [31:0] v, r;
    for (int b = 0; b < 64; b++) mem[src + b] = pat(src + b);
    for (int b = 0; b < 32; b++) begin mem[dst + b] = 8'h00; expm[dst + b] = 8'h00; end
    for (int k = 0; k < 4; k++) begin
      int sa = src + (pinc ? (k << psz) : 0);
      int da = dst + (minc ? (k << msz) : 0);
      v = {pat(sa + 3), pat(sa + 2), pat(sa + 1), pat(sa)};
      if (psz == 2'd0) v &= 32'hFF; else if (psz == 2'd1) v &= 32'hFFFF;
      for (int j = 0; j < (1 << msz); j++) expm[da + j] = v[8*j +: 8];
    end
    setup(0, src, dst, 4);
    wr(ra(0, 0), mk(1, 0, circ, 1, pinc, minc, psz, msz, 2'd0, 3'b011));
    wait_bit(1, "R7 copy completes");
    repeat (4) @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      load_word(dst + 4 * w, r);
      chk($sformatf("R4 psz=%0d msz=%0d pinc=%0d minc=%0d word %0d", psz, msz, pinc, minc, w),
          r, {expm[dst + 4*w + 3], expm[dst + 4*w + 2], expm[dst + 4*w + 1], expm[dst + 4*w]});
    end
  endtask

  initial begin
    logic [31:0] d, e;
    for (int a = 0; a < 1024; a++) mem[a] = pat(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(A_STAT, d);     chk("R11 status after reset", d, 32'd0);
    rd(ra(2, 1), d);   chk("R11 count after reset", d, 32'd0);
    chk("R11 irq after reset", 32'(irq), 32'd0);
    chk("R11 bus idle after reset", 32'(mem_req), 32'd0);

    // R4 size sweep; first run also checks flags, irq and clear.
    for (int ps = 0; ps < 3; ps++) begin
      for (int ms = 0; ms < 3; ms++) begin
        run_copy(2'(ps), 2'(ms), 1, 1, 0);
        if (ps == 0 && ms == 0) begin
          rd(ra(0, 1), d); chk("R3 count ends at zero", d, 32'd0);
          rd(A_STAT, d);   chk("R9 R10 half and done set", d & 32'h7, 32'h3);
          chk("R10 irq on done", 32'(irq[0]), 32'd1);
          wr(A_CLR, 32'h3);
          rd(A_STAT, d);   chk("R11 clear flags", d, 32'd0);
          chk("R10 irq drops after clear", 32'(irq[0]), 32'd0);
        end
        wr(ra(0, 0), 32'd0);
        wr(A_CLR, 32'hFFF);
      end
    end
    run_copy(2'd2, 2'd0, 0, 1, 0); wr(ra(0, 0), 32'd0); wr(A_CLR, 32'hFFF);
    run_copy(2'd1, 2'd2, 1, 0, 0); wr(ra(0, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R8 circular ignored in memory-to-memory
    run_copy(2'd2, 2'd2, 1, 1, 1);
    repeat (20) @(negedge clk);
    rd(ra(0, 1), d); chk("R8 m2m ignores circular", d, 32'd0);
    chk("R7 bus idle after m2m", 32'(mem_req), 32'd0);
    wr(ra(0, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R5 R6 R9 peripheral mode, memory side read, ch1
    setup(1, 'h300, 'h080, 3);
    wr(ra(1, 0), mk(1, 1, 0, 0, 1, 1, 2'd2, 2'd2, 2'd0, 3'b000));
    repeat (20) @(negedge clk);
    rd(ra(1, 1), d); chk("R6 no item without request", d, 32'd3);
    serve(1);
    rd(A_STAT, d); chk("R9 half not yet after one of three", 32'(d[3]), 32'd0);
    serve(1);
    rd(A_STAT, d); chk("R9 half at count one of three", 32'(d[3]), 32'd1);
    serve(1);
    rd(A_STAT, d); chk("R10 done after three", 32'(d[4]), 32'd1);
    for (int k = 0; k < 3; k++) begin
      load_word('h300 + 4 * k, d);
      e = {pat('h80 + 4*k + 3), pat('h80 + 4*k + 2), pat('h80 + 4*k + 1), pat('h80 + 4*k)};
      chk($sformatf("R5 memory-to-peripheral word %0d", k), d, e);
    end
    wr(ra(1, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R8 circular reload, ch2
    setup(2, 'h040, 'h380, 2);
    wr(ra(2, 0), mk(1, 0, 1, 0, 0, 1, 2'd2, 2'd2, 2'd0, 3'b000));
    serve(2); serve(2);
    rd(ra(2, 1), d); chk("R8 count reloads", d, 32'd2);
    rd(ra(2, 3), d); chk("R8 memory address reloads", d, 32'h380);
    rd(A_STAT, d);   chk("R10 done on wrap", 32'(d[7]), 32'd1);
    serve(2);
    rd(ra(2, 3), d); chk("R4 R8 step after reload", d, 32'h384);
    rd(ra(2, 1), d); chk("R3 count after reload item", d, 32'd1);
    wr(ra(2, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R1 priority: ch3 level 3 beats ch1 level 1
    setup(1, 'h010, 'h3C0, 1);
    setup(3, 'h020, 'h3D0, 1);
    wr(ra(1, 0), mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd1, 3'b000));
    wr(ra(3, 0), mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd3, 3'b000));
    armed = 1'b1;
    fork serve(1); serve(3); join
    chk("R1 higher level first", first_rd, 32'h20);
    wr(ra(1, 0), 32'd0); wr(ra(3, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R2 tie: ch0 beats ch2 at equal level
    setup(0, 'h030, 'h3C0, 1);
    setup(2, 'h050, 'h3D0, 1);
    wr(ra(2, 0), mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd2, 3'b000));
    wr(ra(0, 0), mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd2, 3'b000));
    armed = 1'b1;
    fork serve(0); serve(2); join
    chk("R2 tie to lower index", first_rd, 32'h30);
    wr(ra(0, 0), 32'd0); wr(ra(2, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R13 preemption between items
    setup(3, 'h060, 'h3E0, 1);
    wr(ra(3, 0), mk(1, 0, 0, 0, 1, 1, 2'd2, 2'd2, 2'd3, 3'b000));
    setup(0, 'h000, 'h100, 20);
    wr(ra(0, 0), mk(1, 0, 0, 1, 1, 1, 2'd2, 2'd2, 2'd0, 3'b000));
    repeat (5) @(negedge clk);
    serve(3);
    rd(ra(0, 1), d); chk("R13 long run still pending", 32'(d != 0), 32'd1);
    rd(ra(3, 1), d); chk("R13 urgent channel served", d, 32'd0);
    wait_bit(1, "R7 long run completes");
    wr(ra(0, 0), 32'd0); wr(ra(3, 0), 32'd0); wr(A_CLR, 32'hFFF);

    // R12 bus error confined to ch1
    setup(0, 'h000, 'h100, 6);
    setup(1, 32'h8000_0000, 'h140, 2);
    wr(ra(0, 0), mk(1, 0, 0, 1, 1, 1, 2'd2, 2'd2, 2'd0, 3'b000));
    wr(ra(1, 0), mk(1, 0, 0, 1, 1, 1, 2'd2, 2'd2, 2'd3, 3'b100));
    wait_bit(1, "R12 other channel completes");
    rd(A_STAT, d);   chk("R12 error flag", 32'(d[5]), 32'd1);
    rd(ra(1, 0), d); chk("R12 enable cleared", 32'(d[0]), 32'd0);
    rd(ra(1, 1), d); chk("R12 count unchanged", d, 32'd2);
    rd(ra(0, 1), d); chk("R12 other channel count", d, 32'd0);
    chk("R10 error irq", 32'(irq[1]), 32'd1);

    // R11 selective clear
    wr(A_CLR, 32'h20);
    rd(A_STAT, d); chk("R11 only cleared bit drops", d, 32'h3);
    chk("R10 error irq drops", 32'(irq[1]), 32'd0);

    summary();
    $finish;
  end
endmodule